// File: doc/BRIEF.md
# Programmable Periodic Interrupt Generator

This block turns a 32.768 kHz tick into a periodic interrupt whose rate is picked by a 4-bit code. A 15-bit counter runs freely and advances once per tick. When periodic interrupts are enabled and the code is nonzero, an event fires on every tick where the counter sits on a multiple of the selected period. The period is a power of two.

Each event raises a periodic flag, a summary flag and an active-high interrupt request. All three stay high until a one-cycle clear strobe arrives. This strobe stands for a read of the status register. Codes 1 and 2 are the slow aliases of codes 8 and 9. Events are aligned to the free-running count, so changing the rate never restarts the timing.

Top module: `periodic_irq_gen`

## Requirements
- R1: A synchronous active-high reset clears the counter, both flags and the interrupt. After reset the first tick sees a count of 0.
- R2: No event occurs while the enable input is low, or while the rate code is 0.
- R3: For codes 3 to 15 the period is 2^(code-1) ticks. Code 3 gives 4 ticks, code 6 gives 32 and code 15 gives 16384.
- R4: Code 1 behaves as code 8 (128 ticks) and code 2 behaves as code 9 (256 ticks).
- R5: An event fires on a tick whose counter value is a multiple of the period. The timing is not measured from the moment the code or the enable was changed.
- R6: An event drives the periodic flag, the summary flag and the interrupt high in the next clock cycle, and the three outputs are always equal.
- R7: The flags and the interrupt hold their value until the clear strobe is high in a cycle. They are then low in the next cycle unless an event occurred in that same cycle.
- R8: An event in the same cycle as the clear strobe wins, and the flags stay set.
- R9: The counter advances only on clock cycles where the tick enable is high, and events occur only on such cycles. With a tick every k clocks, the spacing between events is k times the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tickEn | input | 1 | One-cycle enable at the 32.768 kHz rate |
| rateCode | input | 4 | Rate select code |
| periodicEn | input | 1 | Periodic interrupt enable |
| flagClr | input | 1 | One-cycle flag clear (status read) |
| flagSummary | output | 1 | Summary interrupt flag |
| flagPeriodic | output | 1 | Periodic event flag |
| irq | output | 1 | Active-high interrupt request |

## Verification
On every cycle the assertions check several properties:
- the counter steps by one per tick and holds between ticks;
- the flags hold or clear according to the strobe, and an event beats a clear;
- the three outputs stay equal;
- a flag that is low stays low while the generator is disabled.

The actual spacing between events for each code, the aliasing of codes 1 and 2, and the alignment to the free-running count are shown only by the bench. The bench measures the gaps between events and the delay to the first event after an unaligned enable, and it compares every cycle against its own model.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef struct packed {
    logic countStep;
    logic raiseFlags;
    logic dropFlags;
  } pitStrobes_t;
endpackage

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int CNT_W    = 15,
  parameter int CODE_W   = 4,
  parameter int ALIAS_MAX = 2,
  parameter int ALIAS_ADD = 7
) (
  input  logic              tickEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              periodicEn,
  input  logic              flagClr,
  input  logic [CNT_W-1:0]  countVal,
  output pitStrobes_t       strb
);
  logic [CODE_W-1:0] effCode;
  logic [CNT_W-1:0]  lowMask;
  logic              onBoundary;

  // slow aliases for the smallest nonzero codes
  always_comb begin
    if (rateCode != '0 && int'(rateCode) <= ALIAS_MAX)
      effCode = rateCode + CODE_W'(ALIAS_ADD);
    else
      effCode = rateCode;
  end

  // bits below the period's bit position must be zero
  always_comb begin
    for (int i = 0; i < CNT_W; i++)
      lowMask[i] = ((i + 1) < int'(effCode));
  end

  assign onBoundary = ((countVal & lowMask) == '0);

  always_comb begin
    strb.countStep  = tickEn;
    strb.raiseFlags = tickEn && periodicEn && (effCode != '0) && onBoundary;
    strb.dropFlags  = flagClr;
  end
endmodule

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  pitStrobes_t      strb,
  output logic [CNT_W-1:0] countVal,
  output logic             summaryQ,
  output logic             periodicQ,
  output logic             irqQ
);
  always_ff @(posedge clk) begin
    if (rst) countVal <= '0;
    else if (strb.countStep) countVal <= countVal + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      summaryQ  <= 1'b0;
      periodicQ <= 1'b0;
      irqQ      <= 1'b0;
    end else if (strb.raiseFlags) begin
      summaryQ  <= 1'b1;
      periodicQ <= 1'b1;
      irqQ      <= 1'b1;
    end else if (strb.dropFlags) begin
      summaryQ  <= 1'b0;
      periodicQ <= 1'b0;
      irqQ      <= 1'b0;
    end
  end

  assert_count_step_R9: assert property (@(posedge clk) disable iff (rst)
    strb.countStep |=> countVal == $past(countVal) + 1'b1);
  assert_count_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !strb.countStep |=> $stable(countVal));
  assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
    strb.raiseFlags |=> periodicQ);
  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (strb.dropFlags && !strb.raiseFlags) |=> !periodicQ);
  assert_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!strb.dropFlags && !strb.raiseFlags) |=> $stable(periodicQ));
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
  import pit_pkg::*;
#(
  parameter int CNT_W  = 15,
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic [CODE_W-1:0] rateCode,
  input  logic              periodicEn,
  input  logic              flagClr,
  output logic              flagSummary,
  output logic              flagPeriodic,
  output logic              irq
);
  pitStrobes_t      strb;
  logic [CNT_W-1:0] countVal;

  pit_ctrl #(.CNT_W(CNT_W), .CODE_W(CODE_W)) u_ctrl (
    .tickEn(tickEn), .rateCode(rateCode), .periodicEn(periodicEn),
    .flagClr(flagClr), .countVal(countVal), .strb(strb));

  pit_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .countVal(countVal),
    .summaryQ(flagSummary), .periodicQ(flagPeriodic), .irqQ(irq));

  assert_flags_equal_R6: assert property (@(posedge clk) disable iff (rst)
    (flagSummary == flagPeriodic) && (irq == flagPeriodic));
  assert_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    ((!periodicEn || rateCode == '0) && !flagPeriodic) |=> !flagPeriodic);
endmodule

// File: tb/tb_periodic_irq_gen.sv
module tb_periodic_irq_gen;
  logic clk = 1'b0;
  logic rst, tickEn, periodicEn, flagClr;
  logic [3:0] rateCode;
  logic flagSummary, flagPeriodic, irq;
  int checks = 0, failures = 0;
  int tickDiv = 1;
  int clkNum = 0;
  string phase = "R1";
  int refCnt = 0;
  bit refFlag = 0;
  bit cmpOn = 0;

  always #4 clk = ~clk;

  periodic_irq_gen dut (.clk(clk), .rst(rst), .tickEn(tickEn), .rateCode(rateCode),
    .periodicEn(periodicEn), .flagClr(flagClr), .flagSummary(flagSummary),
    .flagPeriodic(flagPeriodic), .irq(irq));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int periodOf(input int code);
    int c = code;
    if (c == 1 || c == 2) c = c + 7;
    if (c == 0) return 0;
    return 2 ** (c - 1);
  endfunction

  // behavioural reference model
  always @(posedge clk) begin
    if (rst) begin
      refCnt  <= 0;
      refFlag <= 0;
    end else begin
      if (tickEn && periodicEn && periodOf(int'(rateCode)) != 0 &&
          (refCnt % periodOf(int'(rateCode))) == 0)
        refFlag <= 1;
      else if (flagClr)
        refFlag <= 0;
      if (tickEn) refCnt <= (refCnt + 1) % 32768;
    end
  end

  always @(negedge clk) begin
    if (cmpOn && !rst) begin
      check({phase, " periodic"}, int'(flagPeriodic), int'(refFlag));
      check({phase, " summary R6"}, int'(flagSummary), int'(refFlag));
      check({phase, " irq R6"}, int'(irq), int'(refFlag));
    end
  end

  // tick generator
  initial begin
    tickEn = 1'b0;
    forever begin
      @(negedge clk);
      clkNum++;
      tickEn = ((clkNum % tickDiv) == 0);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic measureGap(input int code, input int div, input int expGap, input string tag);
    int gap = 0;
    int guard = 0;
    phase = tag;
    tickDiv = div;
    rateCode = 4'(code);
    periodicEn = 1'b1;
    flagClr = 1'b1;
    repeat (3) @(negedge clk);
    while (!flagPeriodic && guard < 40000) begin @(negedge clk); guard++; end
    @(negedge clk);
    gap = 1;
    while (!flagPeriodic && gap < 40000) begin @(negedge clk); gap++; end
    check({tag, " event gap"}, gap, expGap);
    // R8: flag was set although the clear strobe was held high
    check({tag, " R8 set beats clear"}, int'(flagPeriodic), 1);
  endtask

  initial begin
    rst = 1'b1; rateCode = 4'd0; periodicEn = 1'b0; flagClr = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset flag", int'(flagPeriodic), 0);
    check("R1 reset irq", int'(irq), 0);
    rst = 1'b0;
    cmpOn = 1;

    // R2: disabled, or code zero
    phase = "R2";
    rateCode = 4'd3; periodicEn = 1'b0;
    repeat (50) @(negedge clk);
    check("R2 disabled no event", int'(irq), 0);
    rateCode = 4'd0; periodicEn = 1'b1;
    repeat (50) @(negedge clk);
    check("R2 code zero no event", int'(irq), 0);

    // R5: enable when the count is unaligned
    phase = "R5";
    periodicEn = 1'b0; rateCode = 4'd5; flagClr = 1'b1;
    while ((refCnt % 16) != 5) @(negedge clk);
    flagClr = 1'b0;
    periodicEn = 1'b1;
    begin
      int n = 0;
      while (!flagPeriodic && n < 100) begin @(negedge clk); n++; end
      check("R5 first event aligned", n, 12);
    end

    // R7: hold then clear
    phase = "R7";
    periodicEn = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 flag held", int'(flagPeriodic), 1);
    flagClr = 1'b1;
    @(negedge clk);
    flagClr = 1'b0;
    check("R7 flag cleared", int'(flagPeriodic), 0);
    repeat (5) @(negedge clk);
    check("R7 stays clear", int'(irq), 0);

    measureGap(3, 1, 4, "R3 code3");
    measureGap(6, 1, 32, "R3 code6");
    measureGap(1, 1, 128, "R4 code1");
    measureGap(2, 1, 256, "R4 code2");
    measureGap(3, 2, 8, "R9 tick/2 code3");
    measureGap(4, 3, 24, "R9 tick/3 code4");
    measureGap(15, 1, 16384, "R3 code15");

    // R1: reset in the middle of a run
    phase = "R1";
    tickDiv = 1; rateCode = 4'd3; flagClr = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 flag before reset", int'(flagPeriodic), 1);
    rst = 1'b1; periodicEn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    check("R1 mid-run reset clears", int'(irq), 0);
    repeat (10) @(negedge clk);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule